// File: doc/BRIEF.md
# Guarded Flash Write-Sequence Decoder

This block sits between a host's parallel flash bus and the model of a flash array. It watches each bus write cycle, which is framed by the chip-select and write-enable strobes and gated by the output-enable strobe, and records the address and data of every write that qualifies. A state machine then checks the writes against the unlock keys that guard every change to the array. When a key is wrong the decoder drops back to idle. When a complete sequence arrives, it issues a single-cycle start pulse for word program, sector erase, block erase or chip erase, together with the target address and data. A mode register switches between normal array reads and the query-table mode.

The strobes reach the block already synchronised to `clk`. A write cycle is the interval during which chip select and write enable are both low. The address is taken in the first clock of that interval, which is the later of the two falling edges. The data is taken in its last clock, which is the earlier of the two rising edges. While the array model raises `busy_i`, every write is ignored.

States of the sequence machine are IDLE, KEY1 (first key seen), KEY2 (both keys seen), PROG (waiting for the program word), ERS3 (erase set-up seen), ERS4 (erase first key repeated) and ERS5 (erase second key repeated). The transitions are:
- IDLE to KEY1 on AAh at 5555h.
- KEY1 to KEY2 on 55h at 2AAAh.
- KEY2 to PROG on A0h at 5555h.
- KEY2 to ERS3 on 80h at 5555h.
- KEY2 to IDLE with a mode change on 98h or F0h at 5555h.
- PROG to IDLE with a program start on any write.
- ERS3 to ERS4 on AAh at 5555h.
- ERS4 to ERS5 on 55h at 2AAAh.
- ERS5 to IDLE, with an erase start when the command is valid.
- Any unexpected write returns the machine to IDLE.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write is counted only while chip select and write enable are both low and output enable is high. Its address is the bus address in the first low clock. Its data is the bus data in the last low clock.
- R2: A low interval shorter than MIN_LOW clocks (default 3) is not a write and leaves the sequence state unchanged.
- R3: If output enable is low in any clock of the low interval, the write is discarded.
- R4: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any fourth write, give one `prog_start` pulse. On that pulse `tgt_addr` and `tgt_data` carry the fourth write's full address and full 16-bit data.
- R5: The erase prefix is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. The prefix followed by 30h at any address pulses `sect_erase_start`, with `tgt_addr` set to that address with bits 10:0 cleared.
- R6: The erase prefix followed by 50h at any address pulses `blk_erase_start`, with `tgt_addr` set to that address with bits 14:0 cleared.
- R7: The erase prefix followed by 10h at 5555h pulses `chip_erase_start`, with `tgt_addr` set to 0.
- R8: The writes AAh@5555h, 55h@2AAAh and 98h@5555h set `cfi_mode` to 1. It returns to 0 only after a single F0h write in IDLE at any address, the same three-cycle form ending in F0h at 5555h, or reset.
- R9: A write that does not match the expected key sends the machine to IDLE. A following sequence must start again from its first cycle.
- R10: While `busy_i` is high, writes are ignored and neither the sequence state nor the mode changes.
- R11: Key matching compares only data bits 7:0 and address bits 15:0. Data bits 15:8 and address bits 18:16 may hold any value.
- R12: Each start pulse lasts one clock. At most one start is high at a time, and the machine is back in IDLE after the pulse.
- R13: After reset, all starts are 0, `cfi_mode` is 0 and the machine is in IDLE. Reset in the middle of a sequence discards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel_n | input | 1 | Synchronised chip select, active low |
| wr_en_n | input | 1 | Synchronised write enable, active low |
| out_en_n | input | 1 | Synchronised output enable, active low |
| bus_addr | input | 19 | Word address bus |
| bus_data | input | 16 | Write data bus |
| busy_i | input | 1 | Array model is busy with a program or erase |
| prog_start | output | 1 | One-clock word-program start |
| sect_erase_start | output | 1 | One-clock sector-erase start |
| blk_erase_start | output | 1 | One-clock block-erase start |
| chip_erase_start | output | 1 | One-clock chip-erase start |
| tgt_addr | output | 19 | Target word address, or aligned sector/block base |
| tgt_data | output | 16 | Word to be programmed |
| cfi_mode | output | 1 | 1 while in query-table mode |

## Verification
The assertions check, on every cycle, the properties that can be stated locally:
- a qualified write is reported only after a strobe has risen and after at least one clock of both strobes low;
- start pulses are exclusive and last one clock;
- no start follows a clock in which `busy_i` was high;
- the mode register changes only just after a reported write.

The bench scenarios cover the behaviour that depends on a whole sequence:
- the key order for each command;
- aborts on a wrong key, a pulse that is too short or output enable held low;
- busy writes, shown by resuming a sequence afterwards;
- the sector and block alignment of the target address;
- the data being taken at the end of the strobe rather than at its start.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_ERS3,
        ST_ERS4,
        ST_ERS5
    } seq_state_e;

    typedef enum logic {
        MODE_ARRAY = 1'b0,
        MODE_QUERY = 1'b1
    } rd_mode_e;

    localparam int unsigned KEY_AW = 16;

    localparam logic [KEY_AW-1:0] ADR_KEY_A = 16'h5555;
    localparam logic [KEY_AW-1:0] ADR_KEY_B = 16'h2AAA;

    localparam logic [7:0] DAT_KEY_A   = 8'hAA;
    localparam logic [7:0] DAT_KEY_B   = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERS_PREP = 8'h80;
    localparam logic [7:0] OP_CHIP     = 8'h10;
    localparam logic [7:0] OP_SECTOR   = 8'h30;
    localparam logic [7:0] OP_BLOCK    = 8'h50;
    localparam logic [7:0] OP_QUERY    = 8'h98;
    localparam logic [7:0] OP_EXIT     = 8'hF0;

endpackage

// File: rtl/wr_cycle_capture.sv
module wr_cycle_capture #(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned MIN_LOW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              cyc_v,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data
);
    localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LOW);

    logic             both_low;
    logic             low_d;
    logic             spoil;
    logic [CNT_W-1:0] low_cnt;

    always_comb both_low = !chip_sel_n && !wr_en_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_d    <= 1'b0;
            spoil    <= 1'b0;
            low_cnt  <= '0;
            cyc_v    <= 1'b0;
            cyc_addr <= '0;
            cyc_data <= '0;
        end else begin
            low_d <= both_low;
            cyc_v <= 1'b0;
            if (both_low) begin
                cyc_data <= bus_data;
                if (!low_d) begin
                    cyc_addr <= bus_addr;
                    low_cnt  <= CNT_W'(1);
                    spoil    <= !out_en_n;
                end else begin
                    if (low_cnt < CNT_MIN) low_cnt <= low_cnt + CNT_W'(1);
                    spoil <= spoil | !out_en_n;
                end
            end else if (low_d) begin
                cyc_v <= (low_cnt >= CNT_MIN) && !spoil;
            end
        end
    end

    // R1
    cyc_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_v |-> $past(chip_sel_n || wr_en_n));

    // R2
    cyc_had_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_v |-> $past(!chip_sel_n && !wr_en_n, 2));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SECT_W = 11,
    parameter int unsigned BLK_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_v,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_data,
    input  logic              busy_i,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              cfi_mode
);
    seq_state_e state, nxt_state;
    rd_mode_e   mode, nxt_mode;
    logic       go_prog, go_sect, go_blk, go_chip;
    logic       at_a, at_b;
    logic [7:0] lo;

    always_comb begin
        at_a      = cyc_addr[KEY_AW-1:0] == ADR_KEY_A;
        at_b      = cyc_addr[KEY_AW-1:0] == ADR_KEY_B;
        lo        = cyc_data[7:0];
        nxt_state = state;
        nxt_mode  = mode;
        go_prog   = 1'b0;
        go_sect   = 1'b0;
        go_blk    = 1'b0;
        go_chip   = 1'b0;
        if (cyc_v && !busy_i) begin
            unique case (state)
                ST_IDLE: begin
                    if (at_a && lo == DAT_KEY_A) nxt_state = ST_KEY1;
                    else if (lo == OP_EXIT)      nxt_mode  = MODE_ARRAY;
                end
                ST_KEY1: nxt_state = (at_b && lo == DAT_KEY_B) ? ST_KEY2 : ST_IDLE;
                ST_KEY2: begin
                    nxt_state = ST_IDLE;
                    if (at_a) begin
                        case (lo)
                            OP_PROGRAM:  nxt_state = ST_PROG;
                            OP_ERS_PREP: nxt_state = ST_ERS3;
                            OP_QUERY:    nxt_mode  = MODE_QUERY;
                            OP_EXIT:     nxt_mode  = MODE_ARRAY;
                            default:     nxt_state = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: begin
                    go_prog   = 1'b1;
                    nxt_state = ST_IDLE;
                end
                ST_ERS3: nxt_state = (at_a && lo == DAT_KEY_A) ? ST_ERS4 : ST_IDLE;
                ST_ERS4: nxt_state = (at_b && lo == DAT_KEY_B) ? ST_ERS5 : ST_IDLE;
                ST_ERS5: begin
                    nxt_state = ST_IDLE;
                    go_sect   = lo == OP_SECTOR;
                    go_blk    = lo == OP_BLOCK;
                    go_chip   = at_a && lo == OP_CHIP;
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // state and mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            mode  <= MODE_ARRAY;
        end else begin
            state <= nxt_state;
            mode  <= nxt_mode;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_start       <= 1'b0;
            sect_erase_start <= 1'b0;
            blk_erase_start  <= 1'b0;
            chip_erase_start <= 1'b0;
            tgt_addr         <= '0;
            tgt_data         <= '0;
        end else begin
            prog_start       <= go_prog;
            sect_erase_start <= go_sect;
            blk_erase_start  <= go_blk;
            chip_erase_start <= go_chip;
            if (go_prog) begin
                tgt_addr <= cyc_addr;
                tgt_data <= cyc_data;
            end else if (go_sect) begin
                tgt_addr <= {cyc_addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
            end else if (go_blk) begin
                tgt_addr <= {cyc_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
            end else if (go_chip) begin
                tgt_addr <= '0;
            end
        end
    end

    always_comb cfi_mode = (mode == MODE_QUERY);

    // R12
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, sect_erase_start, blk_erase_start, chip_erase_start}));

    // R12
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    // R10
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || sect_erase_start || blk_erase_start || chip_erase_start)
        |-> $past(!busy_i));

    // R8
    mode_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfi_mode != $past(cfi_mode)) |-> $past(cyc_v && !busy_i));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned MIN_LOW = 3,
    parameter int unsigned SECT_W  = 11,
    parameter int unsigned BLK_W   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              wr_en_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              busy_i,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              cfi_mode
);
    logic              cyc_v;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_data;

    wr_cycle_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MIN_LOW(MIN_LOW)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_sel_n(chip_sel_n),
        .wr_en_n   (wr_en_n),
        .out_en_n  (out_en_n),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .cyc_v     (cyc_v),
        .cyc_addr  (cyc_addr),
        .cyc_data  (cyc_data)
    );

    seq_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SECT_W(SECT_W),
        .BLK_W (BLK_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cyc_v           (cyc_v),
        .cyc_addr        (cyc_addr),
        .cyc_data        (cyc_data),
        .busy_i          (busy_i),
        .prog_start      (prog_start),
        .sect_erase_start(sect_erase_start),
        .blk_erase_start (blk_erase_start),
        .chip_erase_start(chip_erase_start),
        .tgt_addr        (tgt_addr),
        .tgt_data        (tgt_data),
        .cfi_mode        (cfi_mode)
    );

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

    typedef struct packed {
        logic [18:0] a;
        logic [15:0] d;
        logic [3:0]  len;
        logic        oe;
        logic        busy;
        logic [2:0]  kind;   // 0 none, 1 program, 2 sector, 3 block, 4 chip
        logic [18:0] ea;
        logic [15:0] ed;
        logic        cfi;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t v(input logic [18:0] a, input logic [15:0] d,
                               input logic [3:0] len, input logic oe, input logic busy,
                               input logic [2:0] kind, input logic [18:0] ea,
                               input logic [15:0] ed, input logic cfi, input logic [3:0] req);
        return '{a, d, len, oe, busy, kind, ea, ed, cfi, req};
    endfunction

    localparam int NV = 49;
    localparam vec_t VEC [NV] = '{
        // R4 / R1: word program
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd4),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd4),
        v(19'h05555, 16'h00A0, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd4),
        v(19'h12345, 16'hBEEF, 4'd4, 1'b0, 1'b0, 3'd1, 19'h12345, 16'hBEEF, 1'b0, 4'd1),
        // R5: sector erase
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd5),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd5),
        v(19'h05555, 16'h0080, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd5),
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd5),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd5),
        v(19'h3A9C7, 16'h0030, 4'd3, 1'b0, 1'b0, 3'd2, 19'h3A800, 16'h0, 1'b0, 4'd5),
        // R6: block erase
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd6),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd6),
        v(19'h05555, 16'h0080, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd6),
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd6),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd6),
        v(19'h5ABCD, 16'h0050, 4'd3, 1'b0, 1'b0, 3'd3, 19'h58000, 16'h0, 1'b0, 4'd6),
        // R7: chip erase
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd7),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd7),
        v(19'h05555, 16'h0080, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd7),
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd7),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd7),
        v(19'h05555, 16'h0010, 4'd3, 1'b0, 1'b0, 3'd4, 19'h0, 16'h0, 1'b0, 4'd7),
        // R8 / R11: query entry with upper data byte and upper address bits set
        v(19'h05555, 16'hFFAA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd11),
        v(19'h42AAA, 16'h3C55, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd11),
        v(19'h25555, 16'h0098, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b1, 4'd8),
        // R8: single-write exit
        v(19'h00007, 16'h00F0, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd8),
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd8),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd8),
        v(19'h05555, 16'h0098, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b1, 4'd8),
        // R8: three-cycle exit
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b1, 4'd8),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b1, 4'd8),
        v(19'h05555, 16'h00F0, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd8),
        // R9: wrong second key aborts
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd9),
        v(19'h02AAA, 16'h0054, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd9),
        v(19'h05555, 16'h00A0, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd9),
        v(19'h00100, 16'h1234, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd9),
        // R2: short pulse on second key is not a write
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd2),
        v(19'h02AAA, 16'h0055, 4'd2, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd2),
        v(19'h05555, 16'h00A0, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd2),
        v(19'h00010, 16'h1111, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd2),
        // R3: output enable low during second key
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd3),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b1, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd3),
        v(19'h05555, 16'h00A0, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd3),
        v(19'h00020, 16'h2222, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd3),
        // R10: busy write ignored, sequence resumes
        v(19'h05555, 16'h00AA, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd10),
        v(19'h02AAA, 16'h0055, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd10),
        v(19'h00055, 16'h0077, 4'd3, 1'b0, 1'b1, 3'd0, 19'h0, 16'h0, 1'b0, 4'd10),
        v(19'h05555, 16'h00A0, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 16'h0, 1'b0, 4'd10),
        v(19'h00030, 16'h3333, 4'd3, 1'b0, 1'b0, 3'd1, 19'h00030, 16'h3333, 1'b0, 4'd10)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_sel_n = 1'b1;
    logic        wr_en_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic [18:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        busy_i = 1'b0;
    logic        prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
    logic [18:0] tgt_addr;
    logic [15:0] tgt_data;
    logic        cfi_mode;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [2:0]  last_kind = '0;
    logic [18:0] last_addr = '0;
    logic [15:0] last_data = '0;

    always #10 clk = ~clk;

    flash_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
        .out_en_n(out_en_n), .bus_addr(bus_addr), .bus_data(bus_data), .busy_i(busy_i),
        .prog_start(prog_start), .sect_erase_start(sect_erase_start),
        .blk_erase_start(blk_erase_start), .chip_erase_start(chip_erase_start),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .cfi_mode(cfi_mode)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_start)       begin pulses++; last_kind = 3'd1; last_addr = tgt_addr; last_data = tgt_data; end
            if (sect_erase_start) begin pulses++; last_kind = 3'd2; last_addr = tgt_addr; end
            if (blk_erase_start)  begin pulses++; last_kind = 3'd3; last_addr = tgt_addr; end
            if (chip_erase_start) begin pulses++; last_kind = 3'd4; last_addr = tgt_addr; end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [18:0] a, input logic [15:0] d,
                             input int len, input bit oe_low, input bit busy);
        @(negedge clk);
        busy_i     = busy;
        chip_sel_n = 1'b0;
        bus_addr   = a;
        bus_data   = ~d;
        for (int i = 0; i < len; i++) begin
            if (i == 0) wr_en_n = 1'b0;
            if (i == 0) bus_data = (len == 1) ? d : ~d;
            if (i == len - 1) bus_data = d;
            if (oe_low && i == 1) out_en_n = 1'b0;
            @(negedge clk);
            if (i == 0) bus_addr = ~a;
            out_en_n = 1'b1;
        end
        wr_en_n  = 1'b1;
        bus_data = 16'h5A5A;
        @(negedge clk);
        chip_sel_n = 1'b1;
        repeat (4) @(negedge clk);
        busy_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check({prog_start, sect_erase_start, blk_erase_start, chip_erase_start, cfi_mode} == 5'b0,
              "R13", "outputs in reset",
              {59'b0, prog_start, sect_erase_start, blk_erase_start, chip_erase_start, cfi_mode}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cfi_mode == 1'b0 && pulses == 0, "R13", "state after reset release",
              {63'b0, cfi_mode}, 64'h0);

        for (int k = 0; k < NV; k++) begin
            int  p0;
            bit  ok;
            p0 = pulses;
            bus_write(VEC[k].a, VEC[k].d, int'(VEC[k].len), VEC[k].oe, VEC[k].busy);
            ok = ((pulses - p0) == ((VEC[k].kind != 3'd0) ? 1 : 0)) && (cfi_mode == VEC[k].cfi);
            if (VEC[k].kind != 3'd0)
                ok = ok && last_kind == VEC[k].kind && last_addr == VEC[k].ea &&
                     (VEC[k].kind != 3'd1 || last_data == VEC[k].ed);
            check(ok, $sformatf("R%0d", VEC[k].req), $sformatf("vector %0d pulses/kind/addr/data/mode", k),
                  {13'b0, 3'(pulses - p0), last_kind, last_addr, last_data, 8'b0, cfi_mode},
                  {13'b0, 3'(VEC[k].kind != 3'd0), VEC[k].kind, VEC[k].ea, VEC[k].ed, 8'b0, VEC[k].cfi});
        end

        // R13: reset mid-sequence discards the unlock
        begin
            int p0;
            p0 = pulses;
            bus_write(19'h05555, 16'h00AA, 3, 1'b0, 1'b0);
            bus_write(19'h02AAA, 16'h0055, 3, 1'b0, 1'b0);
            do_reset();
            bus_write(19'h05555, 16'h00A0, 3, 1'b0, 1'b0);
            bus_write(19'h00040, 16'h4444, 3, 1'b0, 1'b0);
            check(pulses == p0, "R13", "no program after mid-sequence reset", 64'(pulses - p0), 64'h0);
        end

        // R13: reset clears query mode
        bus_write(19'h05555, 16'h00AA, 3, 1'b0, 1'b0);
        bus_write(19'h02AAA, 16'h0055, 3, 1'b0, 1'b0);
        bus_write(19'h05555, 16'h0098, 3, 1'b0, 1'b0);
        check(cfi_mode == 1'b1, "R8", "query mode entered", {63'b0, cfi_mode}, 64'h1);
        do_reset();
        check(cfi_mode == 1'b0, "R13", "query mode cleared by reset", {63'b0, cfi_mode}, 64'h0);

        // R12: pulse is one clock and machine is idle after it (fresh program works)
        begin
            int p0;
            p0 = pulses;
            bus_write(19'h05555, 16'h00AA, 3, 1'b0, 1'b0);
            bus_write(19'h02AAA, 16'h0055, 3, 1'b0, 1'b0);
            bus_write(19'h05555, 16'h00A0, 3, 1'b0, 1'b0);
            bus_write(19'h7FFFF, 16'h0001, 5, 1'b0, 1'b0);
            bus_write(19'h00050, 16'h5555, 3, 1'b0, 1'b0);
            check(pulses == p0 + 1 && last_addr == 19'h7FFFF && last_data == 16'h0001, "R12",
                  "single one-clock pulse then idle", 64'(pulses - p0), 64'h1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule